// File: doc/BRIEF.md
# Serial-Loaded Octal Output Controller

This block is the digital core of an eight-channel low-side switch. A host loads the on/off pattern over a three-wire serial link: a serial clock, a data line, and a strobe that moves the loaded pattern into an output buffer. A serial data output passes on the bits that leave the last stage, so several devices can sit on one chain. They are loaded with a single long bit stream and updated together by a shared strobe. An active-low enable turns every channel off at once and leaves the buffer as it is.

Each channel has an over-current input. When a channel is switched on and reports over-current, that channel alone is shut down and an active-low fault flag is set. The shutdown and the flag both hold until the next strobe. All serial, control and over-current inputs are sampled by the system clock through a two-flop synchronizer. The serial clock must therefore run several times slower than the system clock (each level held for at least four system clock cycles).

Top module: `octal_out_ctrl`

## Requirements
- R1: A bit is shifted in on each rising edge of the serial clock. After eight shifts and a strobe, the first bit sent drives output 7 and the last bit sent drives output 0 (MSB first; drv_o bit i is channel i).
- R2: While the strobe is high, the output buffer follows the shift register. While the strobe is low, the buffer holds its value whatever is shifted in.
- R3: After each falling edge of the serial clock, sdo_o presents the content of the last shift stage. A stream of 16 bits therefore appears on sdo_o delayed by 8 serial clocks, which lets two devices be chained.
- R4: While en_n_i is high, all outputs are off. When en_n_i returns low, the buffered pattern drives the outputs again without being reloaded.
- R5: During reset (rst_n low), all outputs go off, fault_n_o is high, sdo_o is 0, and the shift register and buffer are cleared.
- R6: An over-current on a channel that is driven on turns off only that channel. The channel stays off after the over-current goes away, until the next strobe rising edge restores it.
- R7: fault_n_o goes low when any channel has been shut down for over-current. It stays low until a strobe rising edge. If the over-current is still present after that edge, the channel trips again and the flag returns low.
- R8: An over-current on a channel that is not being driven (its buffer bit is 0, or the outputs are disabled) has no effect on the outputs or on the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| stb_i | input | 1 | Strobe; buffer is transparent while high |
| en_n_i | input | 1 | Active-low output enable |
| oc_i | input | CH | Per-channel over-current indication |
| sdo_o | output | 1 | Serial data out toward the next device |
| drv_o | output | CH | Channel drive, 1 = switched on |
| fault_n_o | output | 1 | Active-low latched over-current flag |

## Verification
The hardest situation to reach is a strobe that arrives while an over-current is still active. In that case the clear and the set of the trip latch meet, and the channel makes a short retry before it trips again. The stimulus first trips a channel, keeps its over-current input high, and then strobes. It checks that the channel and the flag settle back into the tripped state. The same sequence is then repeated with the over-current removed, to show that the strobe restores the channel. Chaining is covered by streaming sixteen bits and comparing sdo_o, bit by bit, with the first eight bits sent.

// File: rtl/ocd_pkg.sv
// Package: shared types and helpers for the octal output controller.
// Assumes all users sample these control lines in the system clock domain.
package ocd_pkg;

    // Control lines packed in one vector; en_n sits in the top bit.
    typedef struct packed {
        logic en_n;
        logic stb;
        logic sdi;
        logic sck;
    } ctl_t;

    localparam int unsigned CTL_W = 4;
    // Reset image of the synchronized controls: outputs disabled.
    localparam logic [CTL_W-1:0] CTL_RST = 4'b1000;

    // Rising-edge test between the current and the previous sample.
    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    // Falling-edge test between the current and the previous sample.
    function automatic logic fall_of(input logic cur, input logic prev);
        return ~cur & prev;
    endfunction

endpackage

// File: rtl/ocd_sync.sv
// Module: multi-stage synchronizer bank for asynchronous inputs.
// Assumes: each bit is an independent slow level; STAGES >= 2.
module ocd_sync #(
    parameter int unsigned W      = 12,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            // Pass the sample on to let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ocd_shifter.sv
// Module: serial input shift register with chain output.
// Shifts MSB first on a serial clock rise; updates sdo on a serial clock fall.
// Assumes: sck_s/sdi_s are already synchronized and sdi_s is stable at the rise.
module ocd_shifter
    import ocd_pkg::*;
#(
    parameter int unsigned CH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          sdi_s,
    output logic [CH-1:0] shift_q,
    output logic          sdo_o
);
    logic sck_d;
    logic sck_rise;
    logic sck_fall;

    assign sck_rise = rise_of(sck_s, sck_d);
    assign sck_fall = fall_of(sck_s, sck_d);

    // Remember the last serial clock sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Shift a new bit into stage 0; older bits move toward stage CH-1.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (sck_rise) shift_q <= {shift_q[CH-2:0], sdi_s};
    end

    // Present the last stage on the chain output after a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        sdo_o <= 1'b0;
        else if (sck_fall) sdo_o <= shift_q[CH-1];
    end
endmodule

// File: rtl/ocd_latch.sv
// Module: strobe-controlled output buffer.
// Transparent while the strobe is high, holding while it is low; also flags the strobe rise.
// Assumes: stb_s is synchronized.
module ocd_latch
    import ocd_pkg::*;
#(
    parameter int unsigned CH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_s,
    input  logic [CH-1:0] shift_q,
    output logic [CH-1:0] latch_q,
    output logic          stb_rise_o
);
    logic stb_d;

    assign stb_rise_o = rise_of(stb_s, stb_d);

    // Previous strobe sample for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_d <= 1'b0;
        else        stb_d <= stb_s;
    end

    // Follow the shift register while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '0;
        else if (stb_s) latch_q <= shift_q;
    end
endmodule

// File: rtl/ocd_guard.sv
// Module: per-channel over-current trip latches, output gating and fault flag.
// A driven channel that reports over-current trips and is held off until a strobe rise.
// If the set and the clear meet in one cycle, the set wins.
// Assumes: oc_s and en_n_s are synchronized.
module ocd_guard #(
    parameter int unsigned CH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] latch_q,
    input  logic          en_n_s,
    input  logic [CH-1:0] oc_s,
    input  logic          stb_rise,
    output logic [CH-1:0] trip_q,
    output logic [CH-1:0] drv_o,
    output logic          fault_n_o
);
    logic [CH-1:0] trip_next;

    for (genvar c = 0; c < CH; c++) begin : g_chan
        // Next trip state: cleared by a strobe rise, set by over-current on a driven channel.
        always_comb begin
            trip_next[c] = (trip_q[c] & ~stb_rise) | (oc_s[c] & drv_o[c]);
        end

        // Trip latch for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) trip_q[c] <= 1'b0;
            else        trip_q[c] <= trip_next[c];
        end

        // Registered drive: buffered bit, gated by enable and trip.
        always_ff @(posedge clk) begin
            if (!rst_n) drv_o[c] <= 1'b0;
            else        drv_o[c] <= latch_q[c] & ~en_n_s & ~trip_q[c];
        end
    end

    // Registered active-low flag for any tripped channel.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_n_o <= 1'b1;
        else        fault_n_o <= ~(|trip_next);
    end
endmodule

// File: rtl/octal_out_ctrl.sv
// Top: serial-loaded octal output controller.
// Synchronizes the inputs, shifts the serial data, buffers it on the strobe,
// gates the outputs with enable and the over-current trips.
// Assumes: every serial clock level lasts at least four clk cycles.
module octal_out_ctrl
    import ocd_pkg::*;
#(
    parameter int unsigned CH          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_i,
    input  logic          sdi_i,
    input  logic          stb_i,
    input  logic          en_n_i,
    input  logic [CH-1:0] oc_i,
    output logic          sdo_o,
    output logic [CH-1:0] drv_o,
    output logic          fault_n_o
);
    localparam int unsigned SYNC_W = CH + CTL_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{CH{1'b0}}, CTL_RST};

    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    logic [SYNC_W-1:0] sync_q;
    logic [CH-1:0]     oc_s;
    logic              stb_s;
    logic              en_n_s;
    logic              stb_rise;
    logic [CH-1:0]     shift_q;
    logic [CH-1:0]     latch_q;
    logic [CH-1:0]     trip_q;

    // Gather the control pins into one vector.
    always_comb begin
        ctl_raw.en_n = en_n_i;
        ctl_raw.stb  = stb_i;
        ctl_raw.sdi  = sdi_i;
        ctl_raw.sck  = sck_i;
    end

    ocd_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({oc_i, ctl_raw}),
        .q_o   (sync_q)
    );

    assign ctl_s  = ctl_t'(sync_q[CTL_W-1:0]);
    assign oc_s   = sync_q[SYNC_W-1:CTL_W];
    assign stb_s  = ctl_s.stb;
    assign en_n_s = ctl_s.en_n;

    ocd_shifter #(.CH(CH)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (ctl_s.sck),
        .sdi_s   (ctl_s.sdi),
        .shift_q (shift_q),
        .sdo_o   (sdo_o)
    );

    ocd_latch #(.CH(CH)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_s      (stb_s),
        .shift_q    (shift_q),
        .latch_q    (latch_q),
        .stb_rise_o (stb_rise)
    );

    ocd_guard #(.CH(CH)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_q   (latch_q),
        .en_n_s    (en_n_s),
        .oc_s      (oc_s),
        .stb_rise  (stb_rise),
        .trip_q    (trip_q),
        .drv_o     (drv_o),
        .fault_n_o (fault_n_o)
    );
endmodule

// File: rtl/ocd_checker.sv
// Checker: temporal properties of the octal output controller, bound to the top.
module ocd_checker #(
    parameter int unsigned CH = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stb_s,
    input logic          en_n_s,
    input logic          stb_rise,
    input logic [CH-1:0] shift_q,
    input logic [CH-1:0] latch_q,
    input logic [CH-1:0] trip_q,
    input logic [CH-1:0] oc_s,
    input logic [CH-1:0] drv_o,
    input logic          fault_n_o
);
    // R2: the buffer holds while the strobe is low.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_s |=> $stable(latch_q));

    // R2: the buffer takes the shift register while the strobe is high.
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        stb_s |=> (latch_q == $past(shift_q)));

    // R4: disable forces every output off.
    a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> (drv_o == '0));

    // R6: a tripped channel is not driven in the next cycle.
    a_r6_tripped_off: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((drv_o & $past(trip_q)) == '0));

    // R8: a trip appears only on a channel that was driven and reporting over-current.
    a_r8_trip_source: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((trip_q & ~$past(trip_q) & ~$past(oc_s & drv_o)) == '0));

    // R7: any trip shows on the flag.
    a_r7_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip_q) |-> !fault_n_o);

    // R7: the flag stays low until a strobe rise.
    a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n_o && !stb_rise) |=> !fault_n_o);
endmodule

bind octal_out_ctrl ocd_checker #(.CH(CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_s     (stb_s),
    .en_n_s    (en_n_s),
    .stb_rise  (stb_rise),
    .shift_q   (shift_q),
    .latch_q   (latch_q),
    .trip_q    (trip_q),
    .oc_s      (oc_s),
    .drv_o     (drv_o),
    .fault_n_o (fault_n_o)
);

// File: tb/octal_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module octal_out_ctrl_tb_top;
    localparam int CH = 8;
    localparam int PH = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic          stb = 1'b0;
    logic          en_n = 1'b1;
    logic [CH-1:0] oc = '0;
    logic          sdo;
    logic [CH-1:0] drv;
    logic          fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string         req;
        logic [CH-1:0] drv;
        logic          flt_n;
    } exp_t;

    exp_t sb_q[$];
    event chk_ev;

    always #2.5 clk = ~clk;

    octal_out_ctrl #(.CH(CH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (sck),
        .sdi_i     (sdi),
        .stb_i     (stb),
        .en_n_i    (en_n),
        .oc_i      (oc),
        .sdo_o     (sdo),
        .drv_o     (drv),
        .fault_n_o (fault_n)
    );

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each queued expectation with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_val({e.req, " drv"}, int'(drv), int'(e.drv));
                check_val({e.req, " fault_n"}, int'(fault_n), int'(e.flt_n));
            end
        end
    end

    // Driver side: queue an expectation and sample away from the clock edge.
    task automatic expect_out(input string req, input logic [CH-1:0] d, input logic f);
        exp_t e;
        @(negedge clk);
        e.req = req; e.drv = d; e.flt_n = f;
        sb_q.push_back(e);
        ->chk_ev;
        #0.5;
    endtask

    task automatic shift_bit(input logic b);
        sck = 1'b0; sdi = b; idle(PH);
        sck = 1'b1; idle(PH);
    endtask

    task automatic load_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) shift_bit(v[i]);
        sck = 1'b0; idle(PH);
    endtask

    task automatic strobe();
        stb = 1'b1; idle(PH);
        stb = 1'b0; idle(PH);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] stream;
        idle(5);
        // R5: state during reset
        expect_out("R5 in reset", 8'h00, 1'b1);
        @(negedge clk); check_val("R5 sdo in reset", int'(sdo), 0);
        rst_n = 1'b1; en_n = 1'b0; idle(8);
        expect_out("R5 after reset", 8'h00, 1'b1);

        // R2: no strobe means no change
        load_byte(8'hA5);
        expect_out("R2 hold without strobe", 8'h00, 1'b1);
        strobe(); idle(2);
        expect_out("R1 A5 loaded", 8'hA5, 1'b1);
        // R1: the first bit lands on output 7
        load_byte(8'h80); strobe(); idle(2);
        expect_out("R1 msb first", 8'h80, 1'b1);

        // R2: transparent while strobe high, holds after it drops
        stb = 1'b1; idle(PH);
        load_byte(8'h3C); idle(4);
        expect_out("R2 transparent", 8'h3C, 1'b1);
        stb = 1'b0; idle(PH);
        load_byte(8'hFF); idle(4);
        expect_out("R2 held after strobe low", 8'h3C, 1'b1);

        // R4: disable and re-enable
        en_n = 1'b1; idle(8);
        expect_out("R4 disabled", 8'h00, 1'b1);
        en_n = 1'b0; idle(8);
        expect_out("R4 re-enabled", 8'h3C, 1'b1);

        // R3: 16-bit stream, sdo repeats the first byte 8 clocks later
        stream = 16'hC35A;
        for (int k = 0; k < 16; k++) begin
            sck = 1'b0; sdi = stream[15-k]; idle(PH);
            if (k >= 8) begin
                @(negedge clk);
                check_val($sformatf("R3 sdo bit %0d", k - 8), int'(sdo), int'(stream[15-(k-8)]));
            end
            sck = 1'b1; idle(PH);
        end
        sck = 1'b0; idle(PH);
        @(negedge clk);
        check_val("R3 sdo bit 8", int'(sdo), int'(stream[7]));
        strobe(); idle(2);
        expect_out("R3 last byte kept", 8'h5A, 1'b1);

        // R6/R7: over-current on driven channels
        load_byte(8'hFF); strobe(); idle(2);
        expect_out("R6 all on", 8'hFF, 1'b1);
        oc[3] = 1'b1; idle(8); oc[3] = 1'b0; idle(8);
        expect_out("R6 ch3 tripped alone", 8'hF7, 1'b0);
        oc[0] = 1'b1; idle(8); oc[0] = 1'b0; idle(8);
        expect_out("R7 flag still latched", 8'hF6, 1'b0);
        strobe(); idle(4);
        expect_out("R6 R7 strobe restores", 8'hFF, 1'b1);

        // R8: over-current on idle channels is ignored
        load_byte(8'h0F); strobe(); idle(2);
        oc[6] = 1'b1; idle(8); oc[6] = 1'b0; idle(8);
        expect_out("R8 off channel ignored", 8'h0F, 1'b1);
        en_n = 1'b1; idle(4);
        oc[1] = 1'b1; idle(8); oc[1] = 1'b0; idle(8);
        en_n = 1'b0; idle(8);
        expect_out("R8 disabled channel ignored", 8'h0F, 1'b1);

        // R7: strobe while the over-current persists trips again
        oc[2] = 1'b1; idle(8);
        expect_out("R7 ch2 tripped", 8'h0B, 1'b0);
        strobe(); idle(8);
        expect_out("R7 retrip with oc held", 8'h0B, 1'b0);
        oc[2] = 1'b0; idle(4);
        strobe(); idle(4);
        expect_out("R7 cleared after oc gone", 8'h0F, 1'b1);

        // R5: reset in mid run
        rst_n = 1'b0; idle(3);
        expect_out("R5 mid-run reset", 8'h00, 1'b1);
        rst_n = 1'b1; idle(4);
        strobe(); idle(4);
        expect_out("R5 registers cleared", 8'h00, 1'b1);

        idle(4);
        done = 1'b1;
        finish_run();
    end
endmodule